// File: doc/BRIEF.md
# Fault Record Status Register

This block is one 64-bit status word of a fault management unit's error record. Hardware error reports arrive on a strobe with an error kind, an implementation error code, a primary error code and a remote block identifier. The first report opens the record. It marks it valid, flags the record as corrected or uncorrected and loads the codes. Any later report that arrives while the record is open only raises the overflow flag. A software write port closes the record with write-one-to-clear rules. It can also rewrite the code fields that the record index allows.

The record index parameter `REC_IDX` changes the field set. Record 0 captures a remote block ID when a genuine ping-acknowledge timeout (code 19) opens the record, and its primary code cannot be written by software. Other records hold no block ID. Only records 0 and 13 upward keep an implementation code. An injected report, flagged on `rpt_inj`, opens the record like a hardware report but never touches the block ID.

Top module: `err_status_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets all 64 bits of `status_q` to zero.
- R2: The fields sit at block ID [39:32], valid [30], uncorrected [29], overflow [27], corrected [25:24], uncorrected type [21:20], implementation code [15:8], primary code [7:0]. Every other bit always reads 0, even after a write of all ones.
- R3: A report with valid clear opens the record on the next edge. It sets valid to 1 and loads the codes. For an uncorrected report (`rpt_unc`=1) it sets uncorrected=1, type=2'b11 and corrected=2'b00. For a corrected report it sets corrected=2'b10, uncorrected=0 and type=2'b00.
- R4: A report while valid is 1 sets overflow and leaves every other field unchanged.
- R5: Valid, uncorrected, corrected and type clear together only when one write has bits 30, 29 and 25 all at 1. Any other write leaves all four unchanged.
- R6: A write with bit 27 at 1 clears overflow, whatever the other clear bits hold.
- R7: When a report and a write fall in the same cycle, the report is applied and the whole write is ignored.
- R8: In record 0, a non-injected report that opens the record with implementation code 19 loads `rpt_blkid` into the block ID. Every other case holds the block ID, and only reset clears it.
- R9: An injected report never changes the block ID, even when its code is 19. It still opens the record as in R3.
- R10: The implementation code is loaded by reports and written from write bits [15:8] in record 0 and in records 13 and above. In records 1 to 12 it reads 0.
- R11: The primary code is loaded by reports in every record. Write bits [7:0] update it only when `REC_IDX` is not 0.
- R12: In records other than 0 the block ID always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_vld | input | 1 | Error report strobe |
| rpt_inj | input | 1 | Report comes from software injection |
| rpt_unc | input | 1 | 1 = uncorrected error, 0 = corrected |
| rpt_ierr | input | 8 | Implementation error code of the report |
| rpt_serr | input | 8 | Primary error code of the report |
| rpt_blkid | input | 8 | Remote block ID for a ping-acknowledge timeout |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 64 | Software write data |
| status_q | output | 64 | Status word |

## Verification
The main stimulus is a chain of reports and writes on record 0. It covers corrected and uncorrected reports, which tell apart the two kind encodings. Reports on an open record show that overflow is set and the codes are kept. Partial and full clear patterns show that the valid group is coupled while overflow clears on its own. The chain also includes a report and a clear in one cycle. Injected and genuine reports with code 19 show whether the block ID follows only real timeouts. Records 5 and 13 receive the same inputs, which exposes the per-record write permissions and the fields forced to zero.

// File: rtl/err_rec_pkg.sv
package err_rec_pkg;
  localparam int STAT_W   = 64;
  localparam int CODE_W   = 8;
  localparam int BLK_LO   = 32;
  localparam int V_BIT    = 30;
  localparam int UE_BIT   = 29;
  localparam int OF_BIT   = 27;
  localparam int CE_LO    = 24;
  localparam int UET_LO   = 20;
  localparam int IERR_LO  = 8;
  localparam int SERR_LO  = 0;
  localparam logic [1:0] CE_NONE = 2'b00;
  localparam logic [1:0] CE_SOME = 2'b10;
  localparam logic [1:0] UET_UNC = 2'b11;
  localparam logic [STAT_W-1:0] LIVE_MASK = 64'h0000_00FF_6B30_FFFF;
endpackage

// File: rtl/err_rec_wr_dec.sv
module err_rec_wr_dec
  import err_rec_pkg::*;
(
  input  logic              we,
  input  logic              rpt_vld,
  input  logic [STAT_W-1:0] wdata,
  output logic              grp_clr,
  output logic              of_clr,
  output logic              code_wr
);
  logic wr_ok;
  always_comb begin
    wr_ok   = we && !rpt_vld;
    grp_clr = wr_ok && wdata[V_BIT] && wdata[UE_BIT] && wdata[CE_LO+1];
    of_clr  = wr_ok && wdata[OF_BIT];
    code_wr = wr_ok;
  end
endmodule

// File: rtl/err_rec_codes.sv
module err_rec_codes
  import err_rec_pkg::*;
#(
  parameter bit IERR_EN = 1'b1,
  parameter bit SERR_WR = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              wr,
  input  logic [CODE_W-1:0] rpt_ierr,
  input  logic [CODE_W-1:0] rpt_serr,
  input  logic [CODE_W-1:0] w_ierr,
  input  logic [CODE_W-1:0] w_serr,
  output logic [CODE_W-1:0] ierr_q,
  output logic [CODE_W-1:0] serr_q
);
  generate
    if (IERR_EN) begin : g_ierr
      always_ff @(posedge clk) begin
        if (rst)       ierr_q <= '0;
        else if (load) ierr_q <= rpt_ierr;
        else if (wr)   ierr_q <= w_ierr;
      end
    end else begin : g_no_ierr
      assign ierr_q = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                serr_q <= '0;
    else if (load)          serr_q <= rpt_serr;
    else if (wr && SERR_WR) serr_q <= w_serr;
  end

  AST_SERR_RO: assert property (@(posedge clk) disable iff (rst)
    (!SERR_WR && !load) |=> serr_q == $past(serr_q)); // R11
endmodule

// File: rtl/err_rec_blkid.sv
module err_rec_blkid
  import err_rec_pkg::*;
#(
  parameter bit              EN        = 1'b1,
  parameter logic [CODE_W-1:0] PING_CODE = 8'd19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open,
  input  logic              inj,
  input  logic [CODE_W-1:0] ierr_in,
  input  logic [CODE_W-1:0] blk_in,
  output logic [CODE_W-1:0] blk_q
);
  generate
    if (EN) begin : g_blk
      logic cap;
      assign cap = open && !inj && (ierr_in == PING_CODE);
      always_ff @(posedge clk) begin
        if (rst)      blk_q <= '0;
        else if (cap) blk_q <= blk_in;
      end
    end else begin : g_no_blk
      assign blk_q = '0;
    end
  endgenerate

  AST_BLKID_INJ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (open && inj) |=> blk_q == $past(blk_q)); // R9
endmodule

// File: rtl/err_status_reg.sv
module err_status_reg
  import err_rec_pkg::*;
#(
  parameter int                REC_IDX      = 0,
  parameter int                IERR_RW_FROM = 13,
  parameter logic [CODE_W-1:0] PING_CODE    = 8'd19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rpt_vld,
  input  logic              rpt_inj,
  input  logic              rpt_unc,
  input  logic [CODE_W-1:0] rpt_ierr,
  input  logic [CODE_W-1:0] rpt_serr,
  input  logic [CODE_W-1:0] rpt_blkid,
  input  logic              sw_we,
  input  logic [STAT_W-1:0] sw_wdata,
  output logic [STAT_W-1:0] status_q
);
  localparam bit IS_REC0 = (REC_IDX == 0);
  localparam bit IERR_EN = IS_REC0 || (REC_IDX >= IERR_RW_FROM);

  logic              v_q, ue_q, of_q;
  logic [1:0]        ce_q, uet_q;
  logic [CODE_W-1:0] ierr_q, serr_q, blk_q;
  logic              grp_clr, of_clr, code_wr, open;

  assign open = rpt_vld && !v_q;

  err_rec_wr_dec u_dec (
    .we(sw_we), .rpt_vld(rpt_vld), .wdata(sw_wdata),
    .grp_clr(grp_clr), .of_clr(of_clr), .code_wr(code_wr)
  );

  err_rec_codes #(.IERR_EN(IERR_EN), .SERR_WR(!IS_REC0)) u_codes (
    .clk(clk), .rst(rst), .load(open), .wr(code_wr),
    .rpt_ierr(rpt_ierr), .rpt_serr(rpt_serr),
    .w_ierr(sw_wdata[IERR_LO +: CODE_W]), .w_serr(sw_wdata[SERR_LO +: CODE_W]),
    .ierr_q(ierr_q), .serr_q(serr_q)
  );

  err_rec_blkid #(.EN(IS_REC0), .PING_CODE(PING_CODE)) u_blk (
    .clk(clk), .rst(rst), .open(open), .inj(rpt_inj),
    .ierr_in(rpt_ierr), .blk_in(rpt_blkid), .blk_q(blk_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q   <= 1'b0;
      ue_q  <= 1'b0;
      ce_q  <= CE_NONE;
      uet_q <= 2'b00;
    end else if (open) begin
      v_q   <= 1'b1;
      ue_q  <= rpt_unc;
      ce_q  <= rpt_unc ? CE_NONE : CE_SOME;
      uet_q <= rpt_unc ? UET_UNC : 2'b00;
    end else if (grp_clr) begin
      v_q   <= 1'b0;
      ue_q  <= 1'b0;
      ce_q  <= CE_NONE;
      uet_q <= 2'b00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  of_q <= 1'b0;
    else if (rpt_vld && v_q)  of_q <= 1'b1;
    else if (of_clr)          of_q <= 1'b0;
  end

  always_comb begin
    status_q = '0;
    status_q[BLK_LO +: CODE_W]  = blk_q;
    status_q[V_BIT]             = v_q;
    status_q[UE_BIT]            = ue_q;
    status_q[OF_BIT]            = of_q;
    status_q[CE_LO +: 2]        = ce_q;
    status_q[UET_LO +: 2]       = uet_q;
    status_q[IERR_LO +: CODE_W] = ierr_q;
    status_q[SERR_LO +: CODE_W] = serr_q;
  end

  AST_RSVD_ZERO:  assert property (@(posedge clk) disable iff (rst)
    (status_q & ~LIVE_MASK) == '0); // R2
  AST_OPEN_SETS_V: assert property (@(posedge clk) disable iff (rst)
    rpt_vld |=> v_q); // R3
  AST_CE_LEGAL:   assert property (@(posedge clk) disable iff (rst)
    ce_q != 2'b01); // R3
  AST_OVF_KEEP:   assert property (@(posedge clk) disable iff (rst)
    (rpt_vld && v_q) |=> of_q && ierr_q == $past(ierr_q) && serr_q == $past(serr_q)); // R4
  AST_GRP_HOLD:   assert property (@(posedge clk) disable iff (rst)
    (!rpt_vld && !(sw_we && sw_wdata[V_BIT] && sw_wdata[UE_BIT] && sw_wdata[CE_LO+1]))
      |=> v_q == $past(v_q) || v_q); // R5
  AST_UE_NEEDS_V: assert property (@(posedge clk) disable iff (rst)
    ue_q |-> v_q); // R5
  AST_OF_CLR:     assert property (@(posedge clk) disable iff (rst)
    (sw_we && !rpt_vld && sw_wdata[OF_BIT]) |=> !of_q); // R6
  AST_RPT_WINS:   assert property (@(posedge clk) disable iff (rst)
    (rpt_vld && sw_we) |=> v_q && !$past(of_clr && !of_q) || of_q); // R7
endmodule

// File: tb/err_status_reg_bench.sv
module err_status_reg_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        rpt_vld, rpt_inj, rpt_unc, sw_we;
  logic [7:0]  rpt_ierr, rpt_serr, rpt_blkid;
  logic [63:0] sw_wdata;
  logic [63:0] st0, st5, st13;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  err_status_reg #(.REC_IDX(0)) u_err_status_reg (
    .clk(clk), .rst(rst), .rpt_vld(rpt_vld), .rpt_inj(rpt_inj), .rpt_unc(rpt_unc),
    .rpt_ierr(rpt_ierr), .rpt_serr(rpt_serr), .rpt_blkid(rpt_blkid),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .status_q(st0));
  err_status_reg #(.REC_IDX(5)) u_err_status_reg_r5 (
    .clk(clk), .rst(rst), .rpt_vld(rpt_vld), .rpt_inj(rpt_inj), .rpt_unc(rpt_unc),
    .rpt_ierr(rpt_ierr), .rpt_serr(rpt_serr), .rpt_blkid(rpt_blkid),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .status_q(st5));
  err_status_reg #(.REC_IDX(13)) u_err_status_reg_r13 (
    .clk(clk), .rst(rst), .rpt_vld(rpt_vld), .rpt_inj(rpt_inj), .rpt_unc(rpt_unc),
    .rpt_ierr(rpt_ierr), .rpt_serr(rpt_serr), .rpt_blkid(rpt_blkid),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .status_q(st13));

  function automatic logic [63:0] mk(input logic [7:0] blk, input logic v, ue, ovf,
                                      input logic [1:0] ce, uet, input logic [7:0] ie, se);
    logic [63:0] r;
    r = '0;
    r[39:32] = blk; r[30] = v; r[29] = ue; r[27] = ovf;
    r[25:24] = ce; r[21:20] = uet; r[15:8] = ie; r[7:0] = se;
    return r;
  endfunction

  typedef struct packed {
    logic rv, inj, unc;
    logic [7:0] ie, se, blk;
    logic we;
    logic [63:0] wd;
    logic [63:0] ex;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,8'h13,8'h07,8'h5A,1'b0,64'h0,                 mk(8'h5A,1,0,0,2'b10,2'b00,8'h13,8'h07), 8'd8}, // R3 R8 open corrected
    '{1'b1,1'b0,1'b1,8'h22,8'h11,8'h33,1'b0,64'h0,                 mk(8'h5A,1,0,1,2'b10,2'b00,8'h13,8'h07), 8'd4}, // R4 overflow
    '{1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b1,64'h0000_0000_6000_4400, mk(8'h5A,1,0,1,2'b10,2'b00,8'h44,8'h07), 8'd5}, // R5 partial clear
    '{1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b1,64'h0000_0000_6A00_0000, mk(8'h5A,0,0,0,2'b00,2'b00,8'h00,8'h07), 8'd5}, // R5 R6 full clear
    '{1'b1,1'b1,1'b1,8'h13,8'h21,8'h99,1'b0,64'h0,                 mk(8'h5A,1,1,0,2'b00,2'b11,8'h13,8'h21), 8'd9}, // R9 injected
    '{1'b1,1'b0,1'b0,8'h05,8'h06,8'h77,1'b1,64'h0000_0000_6A00_0000, mk(8'h5A,1,1,1,2'b00,2'b11,8'h13,8'h21), 8'd7}, // R7 collision
    '{1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b1,64'h0000_0000_0800_1300, mk(8'h5A,1,1,0,2'b00,2'b11,8'h13,8'h21), 8'd6}, // R6 OF alone
    '{1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b1,64'h0000_0000_6200_0000, mk(8'h5A,0,0,0,2'b00,2'b00,8'h00,8'h21), 8'd5}, // R5 clear
    '{1'b1,1'b0,1'b1,8'h13,8'h01,8'hC3,1'b0,64'h0,                 mk(8'hC3,1,1,0,2'b00,2'b11,8'h13,8'h01), 8'd8}, // R8 real timeout
    '{1'b0,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0,64'h0,                 mk(8'hC3,1,1,0,2'b00,2'b11,8'h13,8'h01), 8'd4}  // R4 idle hold
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rpt_vld = 0; rpt_inj = 0; rpt_unc = 0; rpt_ierr = 0; rpt_serr = 0; rpt_blkid = 0;
    sw_we = 0; sw_wdata = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; idle();
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  initial begin
    rst = 1;
    idle();
    do_reset();
    chk("R1 rec0", st0, '0);
    chk("R1 rec5", st5, '0);
    chk("R1 rec13", st13, '0);

    for (int i = 0; i < NV; i++) begin
      rpt_vld = VEC[i].rv; rpt_inj = VEC[i].inj; rpt_unc = VEC[i].unc;
      rpt_ierr = VEC[i].ie; rpt_serr = VEC[i].se; rpt_blkid = VEC[i].blk;
      sw_we = VEC[i].we; sw_wdata = VEC[i].wd;
      @(negedge clk);
      chk($sformatf("R%0d vec%0d", VEC[i].req, i), st0, VEC[i].ex);
    end
    idle();

    // R1 reset mid-run
    do_reset();
    chk("R1 after use", st0, '0);

    // R10 R11 R12 per-record fields on a report
    rpt_vld = 1; rpt_ierr = 8'h13; rpt_serr = 8'h07; rpt_blkid = 8'h5A;
    @(negedge clk); idle();
    chk("R10 R12 rec5 report", st5, mk(8'h00,1,0,0,2'b10,2'b00,8'h00,8'h07));
    chk("R10 R12 rec13 report", st13, mk(8'h00,1,0,0,2'b10,2'b00,8'h13,8'h07));

    // R10 R11 code writes without clear bits
    sw_we = 1; sw_wdata = 64'h0000_0000_0000_4455;
    @(negedge clk); idle();
    chk("R11 rec0 serr read-only", st0, mk(8'h5A,1,0,0,2'b10,2'b00,8'h44,8'h07));
    chk("R10 rec5 ierr zero", st5, mk(8'h00,1,0,0,2'b10,2'b00,8'h00,8'h55));
    chk("R10 rec13 ierr writable", st13, mk(8'h00,1,0,0,2'b10,2'b00,8'h44,8'h55));

    // R2 all-ones write leaves reserved bits zero
    sw_we = 1; sw_wdata = '1;
    @(negedge clk); idle();
    chk("R2 rec0 all ones", st0, mk(8'h5A,0,0,0,2'b00,2'b00,8'hFF,8'h07));
    chk("R2 rec13 all ones", st13, mk(8'h00,0,0,0,2'b00,2'b00,8'hFF,8'hFF));

    // R8 non-19 code opening the record keeps BLKID
    rpt_vld = 1; rpt_ierr = 8'h12; rpt_serr = 8'h02; rpt_blkid = 8'hEE;
    @(negedge clk); idle();
    chk("R8 other code keeps blkid", st0, mk(8'h5A,1,0,0,2'b10,2'b00,8'h12,8'h02));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule